// File: doc/BRIEF.md
# Ripple-Slice Integer ALU

This block is a purely combinational arithmetic-logic unit for the execute stage of a simple integer pipeline. It takes two operands and a 3-bit operation code. It returns the result, a flag that is high when every result bit is clear, and a signed-overflow flag. The supported operations are bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Branch-on-equal logic reads the zero flag after a subtraction.

The datapath is a ripple chain of identical 1-bit slices. A single invert-and-carry strobe turns the adder into a subtractor: it flips every bit of the second operand and injects a carry of one into the lowest slice. For set-on-less-than, the sign of the subtraction is corrected by the overflow indication. The corrected sign is fed back as the "less" input of the lowest slice, and every other slice receives zero on that input. A small decoder turns the operation code into a packed struct of strobes that drives the datapath. The operand width is a parameter with a default of 32.

Top module: `slice_alu`

## Requirements
- R1: Code 3'b000 gives result = opA AND opB, bit by bit.
- R2: Code 3'b001 gives result = opA OR opB, bit by bit.
- R3: Code 3'b010 gives result = (opA + opB) modulo 2^WIDTH.
- R4: Code 3'b110 gives result = (opA - opB) modulo 2^WIDTH. It is formed by inverting opB and applying a carry-in of one.
- R5: Code 3'b111 gives result bit 0 = 1 exactly when opA < opB as two's-complement numbers, including when opA - opB overflows. Result bits WIDTH-1 down to 1 are zero.
- R6: The zero output is 1 exactly when every result bit is 0, for every code.
- R7: For codes 3'b010 and 3'b110, the overflow output is 1 exactly when the true signed sum or difference falls outside the WIDTH-bit two's-complement range. For every other code, overflow is 0.
- R8: Codes 3'b011, 3'b100 and 3'b101 give an all-zero result, so zero is 1, and give overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when every result bit is 0 |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds two copies of the block. One uses the default WIDTH of 32. It receives directed corner vectors at the extremes of the signed range and a long pseudo-random stream for every code. The other uses WIDTH = 4, which makes it practical to sweep every operand pair under all eight codes. That sweep reaches every overflow combination and every set-on-less-than case where the raw subtraction sign is wrong.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } resSel_e;

  typedef struct packed {
    logic    bInvert;
    logic    carryIn;
    resSel_e resSel;
    logic    resultEn;
    logic    ovfEnable;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobe_t  strobe
);

  always_comb begin
    strobe = '{bInvert: 1'b0, carryIn: 1'b0, resSel: SEL_AND,
               resultEn: 1'b0, ovfEnable: 1'b0};
    unique case (opSel)
      OP_AND: begin
        strobe.resultEn = 1'b1;
      end
      OP_OR: begin
        strobe.resSel   = SEL_OR;
        strobe.resultEn = 1'b1;
      end
      OP_ADD: begin
        strobe.resSel    = SEL_SUM;
        strobe.resultEn  = 1'b1;
        strobe.ovfEnable = 1'b1;
      end
      OP_SUB: begin
        strobe.bInvert   = 1'b1;
        strobe.carryIn   = 1'b1;
        strobe.resSel    = SEL_SUM;
        strobe.resultEn  = 1'b1;
        strobe.ovfEnable = 1'b1;
      end
      OP_SLT: begin
        strobe.bInvert  = 1'b1;
        strobe.carryIn  = 1'b1;
        strobe.resSel   = SEL_LESS;
        strobe.resultEn = 1'b1;
      end
      default: begin
        strobe.resultEn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a,
  input  logic    b,
  input  logic    less,
  input  logic    carryIn,
  input  logic    bInvert,
  input  resSel_e resSel,
  input  logic    resultEn,
  output logic    sum,
  output logic    carryOut,
  output logic    result
);

  logic bEff;
  logic picked;

  assign bEff     = b ^ bInvert;
  assign sum      = a ^ bEff ^ carryIn;
  assign carryOut = (a & bEff) | (a & carryIn) | (bEff & carryIn);

  always_comb begin
    unique case (resSel)
      SEL_AND:  picked = a & bEff;
      SEL_OR:   picked = a | bEff;
      SEL_SUM:  picked = sum;
      SEL_LESS: picked = less;
      default:  picked = 1'b0;
    endcase
  end

  assign result = resultEn & picked;

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic setBit;
  logic ovfRaw;
  logic msbSum;
  logic msbCarryIn;
  logic msbCarryOut;

  for (genvar i = 0; i < WIDTH; i++) begin : gen_bit
    logic cIn;
    logic cOut;
    logic s;
    logic r;
    logic lessIn;

    if (i == 0) begin : g_first
      assign cIn    = strobe.carryIn;
      assign lessIn = setBit;
    end else begin : g_rest
      assign cIn    = gen_bit[i-1].cOut;
      assign lessIn = 1'b0;
    end

    alu_slice u_slice (
      .a        (opA[i]),
      .b        (opB[i]),
      .less     (lessIn),
      .carryIn  (cIn),
      .bInvert  (strobe.bInvert),
      .resSel   (strobe.resSel),
      .resultEn (strobe.resultEn),
      .sum      (s),
      .carryOut (cOut),
      .result   (r)
    );

    assign result[i] = r;
  end

  assign msbSum      = gen_bit[MSB].s;
  assign msbCarryIn  = gen_bit[MSB].cIn;
  assign msbCarryOut = gen_bit[MSB].cOut;

  assign ovfRaw   = msbCarryIn ^ msbCarryOut;
  assign setBit   = msbSum ^ ovfRaw;
  assign overflow = ovfRaw & strobe.ovfEnable;
  assign zero     = ~|result;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  aluStrobe_t strobe;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow
);

  logic [WIDTH-1:0] addRef;
  logic [WIDTH-1:0] subRef;
  logic             addOvf;
  logic             subOvf;

  assign addRef = opA + opB;
  assign subRef = opA - opB;
  assign addOvf = (opA[WIDTH-1] == opB[WIDTH-1]) && (addRef[WIDTH-1] != opA[WIDTH-1]);
  assign subOvf = (opA[WIDTH-1] != opB[WIDTH-1]) && (subRef[WIDTH-1] != opA[WIDTH-1]);

  always_comb begin
    if (!$isunknown({opA, opB, opSel})) begin
      if (opSel == 3'b000) begin
        AST_AND_RESULT: assert (result == (opA & opB)) else $error("and mismatch"); // R1
      end
      if (opSel == 3'b001) begin
        AST_OR_RESULT: assert (result == (opA | opB)) else $error("or mismatch"); // R2
      end
      if (opSel == 3'b010) begin
        AST_ADD_RESULT: assert (result == addRef) else $error("add mismatch"); // R3
        AST_ADD_OVERFLOW: assert (overflow == addOvf) else $error("add overflow mismatch"); // R7
      end
      if (opSel == 3'b110) begin
        AST_SUB_RESULT: assert (result == subRef) else $error("sub mismatch"); // R4
        AST_SUB_OVERFLOW: assert (overflow == subOvf) else $error("sub overflow mismatch"); // R7
        AST_SUB_EQUAL_ZERO: assert (zero == (opA == opB)) else $error("equal test mismatch"); // R6
      end
      if (opSel == 3'b111) begin
        AST_SLT_RESULT: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))})
          else $error("slt mismatch"); // R5
      end
      if (opSel != 3'b010 && opSel != 3'b110) begin
        AST_NO_OVERFLOW: assert (!overflow) else $error("overflow on non-arith code"); // R7
      end
      if (opSel == 3'b011 || opSel == 3'b100 || opSel == 3'b101) begin
        AST_UNUSED_CODE: assert (result == '0 && zero) else $error("unused code not idle"); // R8
      end
    end
  end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_slice_alu.sv
`timescale 1ns/100ps
module sim_slice_alu;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] a0, b0, r0;
  logic [2:0]  op0;
  logic        z0, v0;
  logic [3:0]  a1, b1, r1;
  logic [2:0]  op1;
  logic        z1, v1;

  slice_alu #(.WIDTH(32)) u0 (
    .opA(a0), .opB(b0), .opSel(op0), .result(r0), .zero(z0), .overflow(v0)
  );
  slice_alu #(.WIDTH(4)) u1 (
    .opA(a1), .opB(b1), .opSel(op1), .result(r1), .zero(z1), .overflow(v1)
  );

  typedef struct {
    int          lane;
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] expR;
    logic        expZ;
    logic        expV;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  function automatic item_t model(int lane, int w, logic [2:0] op, logic [31:0] a, logic [31:0] b);
    item_t it;
    longint m, ua, ub, sa, sb, lo, hi, t, r;
    bit v;
    m  = (longint'(1) << w) - 1;
    ua = longint'(a) & m;
    ub = longint'(b) & m;
    sa = ((ua >> (w - 1)) & 1) != 0 ? ua - (longint'(1) << w) : ua;
    sb = ((ub >> (w - 1)) & 1) != 0 ? ub - (longint'(1) << w) : ub;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    r = 0;
    v = 0;
    case (op)
      3'b000: r = ua & ub;
      3'b001: r = ua | ub;
      3'b010: begin t = sa + sb; r = (ua + ub) & m; v = (t > hi) || (t < lo); end
      3'b110: begin t = sa - sb; r = (ua - ub) & m; v = (t > hi) || (t < lo); end
      3'b111: r = (sa < sb) ? 1 : 0;
      default: r = 0;
    endcase
    it.lane = lane; it.op = op; it.a = a; it.b = b;
    it.expR = r[31:0];
    it.expZ = (r == 0);
    it.expV = v;
    return it;
  endfunction

  function automatic string tagFor(logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(int lane, logic [2:0] op, logic [31:0] a, logic [31:0] b);
    @(posedge clk);
    #1;
    if (lane == 0) begin
      op0 = op; a0 = a; b0 = b;
      q.push_back(model(0, 32, op, a, b));
    end else begin
      op1 = op; a1 = a[3:0]; b1 = b[3:0];
      q.push_back(model(1, 4, op, a, b));
    end
  endtask

  task automatic check(string tag, item_t it, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s lane%0d op=%b a=%h b=%h actual=%h expected=%h",
               tag, it.lane, it.op, it.a, it.b, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle and compares at the falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.lane == 0) begin
          check(tagFor(it.op), it, r0, it.expR);
          check("R6", it, {31'b0, z0}, {31'b0, it.expZ});
          check("R7", it, {31'b0, v0}, {31'b0, it.expV});
        end else begin
          check(tagFor(it.op), it, {28'b0, r1}, it.expR);
          check("R6", it, {31'b0, z1}, {31'b0, it.expZ});
          check("R7", it, {31'b0, v1}, {31'b0, it.expV});
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [2:0] ops [5];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    a0 = '0; b0 = '0; op0 = '0; a1 = '0; b1 = '0; op1 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle inputs after reset: AND of zeros gives zero result, zero flag set
    apply(0, 3'b000, 32'h0, 32'h0);
    // R1 / R2 patterns
    apply(0, 3'b000, 32'hF0F0_A5A5, 32'hFF00_0FF0);
    apply(0, 3'b001, 32'hF0F0_A5A5, 32'h0F00_0FF0);
    apply(0, 3'b001, 32'h0, 32'h0);
    // R3 with R7 corners
    apply(0, 3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    apply(0, 3'b010, 32'h8000_0000, 32'h8000_0000);
    apply(0, 3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    // R4 with R6 and R7 corners
    apply(0, 3'b110, 32'h1234_5678, 32'h1234_5678);
    apply(0, 3'b110, 32'h8000_0000, 32'h0000_0001);
    apply(0, 3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R5 including cases where a-b overflows
    apply(0, 3'b111, 32'h8000_0000, 32'h0000_0001);
    apply(0, 3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply(0, 3'b111, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    apply(0, 3'b111, 32'h0000_0005, 32'h0000_0005);
    // R8 unused codes
    apply(0, 3'b011, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    apply(0, 3'b100, 32'h7FFF_FFFF, 32'h0000_0001);
    apply(0, 3'b101, 32'h8000_0000, 32'h8000_0000);
    // pseudo-random stream for every defined code
    seed = 32'h1D2C_3B4A;
    for (int n = 0; n < 1000; n++) begin
      logic [31:0] ra, rb;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      ra = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      rb = (n % 7 == 0) ? ra : seed;
      apply(0, ops[n % 5], ra, rb);
    end
    // exhaustive 4-bit sweep of all codes
    for (int c = 0; c < 8; c++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          apply(1, 3'(c), 32'(x), 32'(y));
        end
      end
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule